// File: doc/BRIEF.md
# Asynchronous Bus Write Capture

This block connects a byte-wide asynchronous memory bus (chip select, output enable and write enable strobes, all active low, plus an address bus and a data input bus) to logic that runs on a single system clock. All three strobes are brought into the clock domain through two-stage synchronisers and then pass through a stability filter, so that a strobe level only counts once it has held for a programmable number of clock cycles. Short glitches on the strobes therefore never open a write.

A write exists only while chip select and write enable are both low and output enable is high, so either strobe can control the cycle. The address is taken at the moment the second of the two strobes falls, and the data is taken at the moment the first of them rises. The address and data buses are delayed through a pipeline that matches the strobe path, so both are captured as they stood on the pins at the strobe edge that mattered. Each completed write appears as a single-cycle valid pulse together with the captured address and data. On the read side the block drives a data-bus output enable while a read is in progress and marks the start of each read with a one-cycle pulse.

Top module: `async_wr_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_valid`, `rd_pulse` and `bus_oe` are low after that edge, and no write performed on the bus while `rst_n` is held low is ever delivered.
- R2: A write opens only while `ce_n` = 0, `we_n` = 0 and `oe_n` = 1 are all seen together. If `oe_n` is held low for the whole strobe sequence, no write is delivered.
- R3: `wr_addr` is the value on `addr` at the falling edge of whichever of `ce_n` and `we_n` falls last. This holds both for write-enable-controlled and for chip-select-controlled cycles. Address changes before that edge and after it have no effect.
- R4: `wr_data` is the value on `din` at the rising edge of whichever of `ce_n` and `we_n` rises first. Data changes after that edge have no effect.
- R5: Each completed write produces exactly one `wr_valid` pulse, one clock cycle wide, in the cycle after the filtered closing edge is detected.
- R6: A low pulse on `ce_n` or `we_n` that lasts fewer than `FILT_CYC` clock cycles does not open a write. A pulse that lasts exactly `FILT_CYC` cycles does open a write.
- R7: `bus_oe` is high after the filtered strobes show `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. It is low at any other time, including when `we_n` is low together with `ce_n` and `oe_n`.
- R8: `rd_pulse` is high for one cycle at the start of each read, and it occurs only in the first cycle in which `bus_oe` is high.
- R9: `wr_valid` and `bus_oe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also halts bus activity |
| ce_n | input | 1 | Chip select from the bus, active low, asynchronous |
| oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| we_n | input | 1 | Write enable from the bus, active low, asynchronous |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Data bus, input direction |
| wr_valid | output | 1 | One-cycle pulse per completed write |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |
| rd_pulse | output | 1 | One-cycle pulse at the start of a read |
| bus_oe | output | 1 | Enable for the data-bus output drivers |

## Verification
The hardest situations to reach from the ports are the ones where the order of the two strobes decides which bus value is kept. The stimulus covers both orders of falling edges and both orders of rising edges. In each write, the address pins carry a different value before the later fall and again after it, and the data pins change one cycle after the first rise while the other strobe is still low. A capture on the wrong edge therefore returns a visibly different value. The filter boundary is reached with write-enable pulses of exactly one cycle less than the filter width and of exactly the filter width, while chip select is held low.

// File: rtl/bwc_pkg.sv
// Shared definitions for the asynchronous bus write capture.
// Assumes: strobes are active low and idle high.
package bwc_pkg;
    localparam int STB_CE  = 0;
    localparam int STB_OE  = 1;
    localparam int STB_WE  = 2;
    localparam int NUM_STB = 3;

    typedef enum logic {
        WT_IDLE = 1'b0,
        WT_OPEN = 1'b1
    } wt_state_e;
endpackage

// File: rtl/bwc_sync.sv
// Two-stage synchroniser for a vector of independent asynchronous bits.
// Assumes: bits are unrelated to each other; the reset value is the idle level.
module bwc_sync #(
    parameter int   W         = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw level through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= {W{RESET_VAL}};
            stage2_q <= {W{RESET_VAL}};
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/bwc_glitch_filter.sv
// Stability filter: the output follows the input only after the input has
// held a new level for FILT_CYC consecutive cycles.
// Assumes: the input is already synchronous; FILT_CYC >= 1.
module bwc_glitch_filter #(
    parameter int   FILT_CYC  = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    // Count cycles of disagreement; accept the new level after FILT_CYC of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= RESET_VAL;
        end else if (level_i != level_q) begin
            if (run_q == LAST) begin
                level_q <= level_i;
                run_q   <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/bwc_delay.sv
// Fixed-depth register pipeline that aligns bus values with the strobe path.
// Assumes: DEPTH >= 1.
module bwc_delay #(
    parameter int W     = 26,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] pipe_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First stage samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= '0;
                else        pipe_q[0] <= d_i;
            end
        end else begin : g_tail
            // Later stages shift the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign d_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/bwc_tracker.sv
// Write and read tracker working on filtered strobes. A write opens when
// CE and WE are low with OE high and latches the address then; it closes
// on the first rise of CE or WE, latching data and pulsing valid.
// Assumes: address and data inputs are delayed to match the strobe path.
module bwc_tracker
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_pulse_o,
    output logic              bus_oe_o
);
    wt_state_e state_q;
    logic      wr_open;
    logic      wr_close;
    logic      rd_cond;

    // Decode the bus phase from the filtered strobes.
    always_comb begin
        wr_open  = !ce_n_i && !we_n_i && oe_n_i;
        wr_close = ce_n_i || we_n_i;
        rd_cond  = !ce_n_i && !oe_n_i && we_n_i;
    end

    // Write phase: open on the later fall, close on the first rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WT_IDLE;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= 1'b0;
            case (state_q)
                WT_IDLE: begin
                    if (wr_open) begin
                        state_q   <= WT_OPEN;
                        wr_addr_o <= addr_i;
                    end
                end
                WT_OPEN: begin
                    if (!oe_n_i) begin
                        state_q <= WT_IDLE;
                    end else if (wr_close) begin
                        state_q    <= WT_IDLE;
                        wr_data_o  <= data_i;
                        wr_valid_o <= 1'b1;
                    end
                end
                default: state_q <= WT_IDLE;
            endcase
        end
    end

    // Read phase: enable the drivers and mark the first read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_oe_o   <= 1'b0;
            rd_pulse_o <= 1'b0;
        end else begin
            bus_oe_o   <= rd_cond;
            rd_pulse_o <= rd_cond && !bus_oe_o;
        end
    end
endmodule

// File: rtl/async_wr_capture.sv
// Top of the asynchronous bus write capture. Strobes are synchronised and
// filtered; address and data are delayed by the same latency so the tracker
// sees all bus signals as they were on the pins at one instant.
// Assumes: address and data meet setup and hold against the strobe edges
// by at least one clock period.
module async_wr_capture
    import bwc_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int FILT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_pulse,
    output logic              bus_oe
);
    localparam int SYNC_STAGES = 2;
    localparam int BUS_DLY     = SYNC_STAGES + FILT_CYC;
    localparam int BUS_W       = ADDR_W + DATA_W;

    logic [NUM_STB-1:0] stb_raw;
    logic [NUM_STB-1:0] stb_sync;
    logic [NUM_STB-1:0] stb_filt;
    logic [BUS_W-1:0]   bus_dly;

    assign stb_raw[STB_CE] = ce_n;
    assign stb_raw[STB_OE] = oe_n;
    assign stb_raw[STB_WE] = we_n;

    bwc_sync #(
        .W         (NUM_STB),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stb_raw),
        .sync_o  (stb_sync)
    );

    for (genvar g = 0; g < NUM_STB; g++) begin : g_filt
        bwc_glitch_filter #(
            .FILT_CYC  (FILT_CYC),
            .RESET_VAL (1'b1)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (stb_sync[g]),
            .level_o (stb_filt[g])
        );
    end

    bwc_delay #(
        .W     (BUS_W),
        .DEPTH (BUS_DLY)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({addr, din}),
        .d_o   (bus_dly)
    );

    bwc_tracker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_i     (stb_filt[STB_CE]),
        .oe_n_i     (stb_filt[STB_OE]),
        .we_n_i     (stb_filt[STB_WE]),
        .addr_i     (bus_dly[BUS_W-1:DATA_W]),
        .data_i     (bus_dly[DATA_W-1:0]),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_pulse_o (rd_pulse),
        .bus_oe_o   (bus_oe)
    );
endmodule

// File: rtl/bwc_checker.sv
// Property checker for async_wr_capture, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module bwc_checker #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_pulse,
    input logic              bus_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !bus_oe && !rd_pulse)); // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R5

    AST_ADDR_HELD_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $stable(wr_addr)); // R3

    AST_RD_PULSE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |-> (bus_oe && !$past(bus_oe))); // R8

    AST_OE_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> rd_pulse); // R8

    AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && bus_oe)); // R9

    AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$isunknown(wr_data)); // R4
endmodule

bind async_wr_capture bwc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_pulse (rd_pulse),
    .bus_oe   (bus_oe)
);

// File: tb/sim_async_wr_capture.sv
module sim_async_wr_capture;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int FILT   = 3;
    localparam int HOLD   = 6;
    localparam int NVEC   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_pulse;
    logic              bus_oe;

    int n_chk = 0;
    int n_bad = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [ADDR_W-1:0] cap_addr = '0;
    logic [DATA_W-1:0] cap_data = '0;
    logic done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    async_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_pulse(rd_pulse), .bus_oe(bus_oe)
    );

    // Record delivered writes and read starts, sampled away from the edge.
    always @(negedge clk) begin
        if (wr_valid) begin
            wcnt     <= wcnt + 1;
            cap_addr <= wr_addr;
            cap_data <= wr_data;
        end
        if (rd_pulse) rcnt <= rcnt + 1;
    end

    typedef struct packed {
        logic              ce_last;       // 1: CE falls second
        logic              ce_rise_first; // 1: CE rises first
        logic              oe_hi;         // OE level during the cycle
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [DATA_W-1:0] dl;            // data driven after the first rise
        logic              exp;           // write expected
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 18'h00555, 8'hAA, 8'h55, 1'b1},
        '{1'b1, 1'b1, 1'b1, 18'h3C002, 8'h5A, 8'hA5, 1'b1},
        '{1'b0, 1'b1, 1'b1, 18'h12345, 8'h0F, 8'hF0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 18'h2AAAA, 8'h81, 8'h7E, 1'b1},
        '{1'b0, 1'b0, 1'b0, 18'h00001, 8'h11, 8'h22, 1'b0},
        '{1'b1, 1'b0, 1'b1, 18'h3FFFF, 8'hFF, 8'h00, 1'b1}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input vec_t v);
        oe_n = v.oe_hi; addr = ~v.a; din = ~v.d;
        cyc(2);
        if (v.ce_last) we_n = 1'b0; else ce_n = 1'b0;
        cyc(HOLD);
        addr = v.a; din = v.d;
        if (v.ce_last) ce_n = 1'b0; else we_n = 1'b0;
        cyc(HOLD);
        addr = v.a ^ 18'h00003;
        cyc(HOLD);
        if (v.ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
        cyc(1);
        din = v.dl;
        cyc(HOLD);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(12);
    endtask

    task automatic we_pulse(input int width);
        addr = 18'h0ABCD; din = 8'h3C; oe_n = 1'b1; ce_n = 1'b0;
        cyc(HOLD);
        we_n = 1'b0;
        cyc(width);
        we_n = 1'b1;
        cyc(HOLD);
        ce_n = 1'b1;
        cyc(12);
    endtask

    initial begin
        int base;
        cyc(5);
        // R1: reset state
        check(!wr_valid && !bus_oe && !rd_pulse, "R1 reset outputs",
              {29'd0, wr_valid, bus_oe, rd_pulse}, 32'd0);
        rst_n = 1'b1;
        cyc(3);

        // R2 R3 R4 R5: vector table of write cycles
        for (int i = 0; i < NVEC; i++) begin
            base = wcnt;
            do_write(VEC[i]);
            check((wcnt - base) == int'(VEC[i].exp), "R2/R5 write count",
                  wcnt - base, VEC[i].exp);
            if (VEC[i].exp) begin
                check(cap_addr == VEC[i].a, "R3 address at later fall",
                      cap_addr, VEC[i].a);
                check(cap_data == VEC[i].d, "R4 data at first rise",
                      cap_data, VEC[i].d);
            end
        end

        // R6: glitch one cycle shorter than the filter is ignored
        base = wcnt;
        we_pulse(FILT - 1);
        check(wcnt == base, "R6 short WE pulse ignored", wcnt - base, 0);
        // R6: short CE glitch with WE held low is ignored
        base = wcnt;
        we_n = 1'b0; oe_n = 1'b1; cyc(HOLD);
        ce_n = 1'b0; cyc(FILT - 1); ce_n = 1'b1; cyc(HOLD);
        we_n = 1'b1; cyc(12);
        check(wcnt == base, "R6 short CE pulse ignored", wcnt - base, 0);
        // R6: pulse of exactly the filter width is accepted
        base = wcnt;
        we_pulse(FILT);
        check((wcnt - base) == 1, "R6 filter-width pulse accepted", wcnt - base, 1);
        check(cap_addr == 18'h0ABCD, "R6 address of accepted pulse", cap_addr, 18'h0ABCD);

        // R7 R8: reads
        base = rcnt;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        cyc(10);
        check(bus_oe == 1'b1, "R7 bus_oe during read", bus_oe, 1);
        check((rcnt - base) == 1, "R8 one rd_pulse per read", rcnt - base, 1);
        oe_n = 1'b1;
        cyc(10);
        check(bus_oe == 1'b0, "R7 bus_oe after OE high", bus_oe, 0);
        oe_n = 1'b0;
        cyc(10);
        check((rcnt - base) == 2, "R8 second read start", rcnt - base, 2);
        we_n = 1'b0;
        cyc(10);
        check(bus_oe == 1'b0, "R7 bus_oe off with WE low", bus_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        cyc(12);

        // R1: reset held low suppresses capture and output enable
        rst_n = 1'b0;
        base = wcnt;
        do_write(VEC[0]);
        check(wcnt == base, "R1 no write under reset", wcnt - base, 0);
        ce_n = 1'b0; oe_n = 1'b0;
        cyc(10);
        check(bus_oe == 1'b0, "R1 bus_oe off under reset", bus_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(4);
        rst_n = 1'b1;
        cyc(12);
        check(wcnt == base, "R1 nothing after reset release", wcnt - base, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule